// File: doc/BRIEF.md
# Loopback Fault-Test Pattern Sequencer

This block tests an 8-bit parallel path that is looped back from a drive port to a return port. A start pulse begins a run. The block then drives a short series of seven words that together expose three kinds of fault: open lines, lines stuck at a level, and bridges between neighbouring bits. An exhaustive sweep of all 256 words is not needed for these faults. The block drives each word, waits a settle time, samples the returned word through a two-stage synchronizer and compares it with the word that was sent.

At the end of a run the block raises a single-cycle completion pulse. It also reports the following results, which stay unchanged until the next start:
- a pass flag;
- a per-bit failure mask;
- two per-bit classification masks, one for lines stuck high and one for lines stuck low.

Top module: `lbt_loopback_tester`

## Requirements
- R1: After reset, busy, done, pass, the failure mask, both stuck masks and the drive output are all zero.
- R2: A run drives, in this order, 0x00, 0xFF, 0x00, 0xAA, 0x55, 0xAA, 0xFF. Each word is held for W = max(settle_cycles,1) + 2 clock cycles.
- R3: Busy rises on the cycle after start is captured. Done is high for exactly one cycle, 7·W cycles after start is captured, and busy is low in that same cycle.
- R4: A start pulse received while busy has no effect. The word order and the length of the run are unchanged.
- R5: The failure mask is the OR, over all seven words, of (sent XOR returned). When a run ends with an all-zero mask, pass is 1; otherwise pass is 0.
- R6: A failing bit that returned 1 every time it was driven to 0 is flagged in the stuck-high mask.
- R7: A failing bit that returned 0 every time it was driven to 1 is flagged in the stuck-low mask.
- R8: A bridge between bits 3 and 4 that forces both to their AND sets failure-mask bits 3 and 4. The stuck masks stay zero for that fault.
- R9: Pass and all masks hold their values after done until the next start. A new start clears them in the first busy cycle.
- R10: A settle_cycles value of 0 is treated as 1. The value is latched at start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| settle_cycles | input | 8 | Settle delay per word, latched at start |
| drive_o | output | 8 | Word driven onto the path under test |
| return_i | input | 8 | Word returned by the path (asynchronous) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | The last run found no mismatch |
| fail_mask | output | 8 | Bits that mismatched in any word |
| stuck1_mask | output | 8 | Failing bits that always returned 1 when driven 0 |
| stuck0_mask | output | 8 | Failing bits that always returned 0 when driven 1 |

## Verification
The assertions assume that the returned word depends only on the driven word and is stable within the settle window. They also assume that start is a clean synchronous pulse. The bench models the path as a combinational function of drive_o, with stuck-high, stuck-low or AND-bridge faults injected. Injected faults change only between runs, never during one. Start is driven away from the clock edge as a one-cycle pulse.

// File: rtl/lbt_pkg.sv
// Package: shared types for the loopback tester.
// Assumes: nothing beyond a standard SystemVerilog elaborator.
package lbt_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } lbt_state_e;
endpackage

// File: rtl/lbt_pattern_rom.sv
// Module: maps a step index to its test word.
// The alternating word is computed per bit, and its complement is also used.
// Assumes: step is in the range 0 to 6; higher values give all ones.
module lbt_pattern_rom #(
    parameter int WIDTH  = 8,
    parameter int STEP_W = 3
) (
    input  logic [STEP_W-1:0] step,
    output logic [WIDTH-1:0]  word
);
    logic [WIDTH-1:0] alt;

    // Build the alternating word: odd bits set, even bits clear.
    for (genvar i = 0; i < WIDTH; i++) begin : g_alt
        assign alt[i] = (i % 2) == 1;
    end

    // Select the word for the current step.
    always_comb begin
        case (step)
            STEP_W'(0): word = '0;
            STEP_W'(1): word = '1;
            STEP_W'(2): word = '0;
            STEP_W'(3): word = alt;
            STEP_W'(4): word = ~alt;
            STEP_W'(5): word = alt;
            default:    word = '1;
        endcase
    end
endmodule

// File: rtl/lbt_sync2.sv
// Module: two-flop synchronizer for the returned word.
// Assumes: each bit is treated independently, and the returned word is stable
// across the settle window so that skew between bits is harmless.
module lbt_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    // Pass the input through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/lbt_fault_acc.sv
// Module: accumulates mismatches and per-bit evidence for classification.
// Assumes: clear and capture are never high together; outputs are only
// meaningful once every word of a run has been captured.
module lbt_fault_acc #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             capture,
    input  logic [WIDTH-1:0] sent,
    input  logic [WIDTH-1:0] got,
    output logic [WIDTH-1:0] mask,
    output logic [WIDTH-1:0] mask_next,
    output logic [WIDTH-1:0] stuck1,
    output logic [WIDTH-1:0] stuck0
);
    logic [WIDTH-1:0] zero_ok;
    logic [WIDTH-1:0] one_ok;

    // Mask after the current compare, used by the parent to decide pass.
    assign mask_next = mask | (capture ? (sent ^ got) : '0);

    // Sticky mismatch mask, plus records of each bit returning 0 or 1 correctly.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            mask    <= '0;
            zero_ok <= '0;
            one_ok  <= '0;
        end else if (capture) begin
            mask    <= mask | (sent ^ got);
            zero_ok <= zero_ok | (~sent & ~got);
            one_ok  <= one_ok | (sent & got);
        end
    end

    // A failing bit with no correct 0 is stuck high; with no correct 1, stuck low.
    assign stuck1 = mask & ~zero_ok;
    assign stuck0 = mask & ~one_ok;
endmodule

// File: rtl/lbt_loopback_tester.sv
// Module: top-level sequencer for the loopback fault test.
// Drives seven test words in turn. Each word is held for the latched settle
// time plus the synchronizer delay, then the synchronized return is compared
// with it. Assumes the returned word depends only on the driven word.
module lbt_loopback_tester #(
    parameter int WIDTH    = 8,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic [WIDTH-1:0]    drive_o,
    input  logic [WIDTH-1:0]    return_i,
    output logic                busy,
    output logic                done,
    output logic                pass,
    output logic [WIDTH-1:0]    fail_mask,
    output logic [WIDTH-1:0]    stuck1_mask,
    output logic [WIDTH-1:0]    stuck0_mask
);
    import lbt_pkg::*;

    localparam int STEPS    = 7;
    localparam int STEP_W   = $clog2(STEPS);
    localparam int SYNC_LAT = 2;
    localparam int CNT_W    = SETTLE_W + 2;

    lbt_state_e          state;
    logic [STEP_W-1:0]   step;
    logic [CNT_W-1:0]    cnt;
    logic [SETTLE_W-1:0] settle_q;
    logic [CNT_W-1:0]    wait_last;
    logic                cmp_now;
    logic                last_step;
    logic [STEP_W-1:0]   rom_step;
    logic [WIDTH-1:0]    rom_word;
    logic [WIDTH-1:0]    ret_sync;
    logic [WIDTH-1:0]    mask_next;
    logic                acc_clear;

    // Compute the last count of a step; a settle time of 0 counts as 1.
    always_comb begin
        wait_last = CNT_W'((settle_q == '0) ? 1 : settle_q) + CNT_W'(SYNC_LAT - 1);
    end

    assign cmp_now   = (state == ST_RUN) && (cnt == wait_last);
    assign last_step = (step == STEP_W'(STEPS - 1));
    assign acc_clear = (state == ST_IDLE) && start;
    assign rom_step  = acc_clear ? '0 : step + STEP_W'(1);
    assign busy      = (state == ST_RUN);

    lbt_pattern_rom #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_rom (
        .step (rom_step),
        .word (rom_word)
    );

    lbt_sync2 #(.WIDTH(WIDTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (return_i),
        .q     (ret_sync)
    );

    lbt_fault_acc #(.WIDTH(WIDTH)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (acc_clear),
        .capture   (cmp_now),
        .sent      (drive_o),
        .got       (ret_sync),
        .mask      (fail_mask),
        .mask_next (mask_next),
        .stuck1    (stuck1_mask),
        .stuck0    (stuck0_mask)
    );

    // Sequencer: start a run, step through the words, then finish with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step     <= '0;
            cnt      <= '0;
            settle_q <= '0;
            drive_o  <= '0;
            done     <= 1'b0;
            pass     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_RUN;
                        step     <= '0;
                        cnt      <= '0;
                        settle_q <= settle_cycles;
                        drive_o  <= rom_word;
                        pass     <= 1'b0;
                    end
                end
                default: begin
                    if (cmp_now) begin
                        cnt <= '0;
                        if (last_step) begin
                            state   <= ST_IDLE;
                            drive_o <= '0;
                            done    <= 1'b1;
                            pass    <= (mask_next == '0);
                        end else begin
                            step    <= step + STEP_W'(1);
                            drive_o <= rom_word;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // R3: done lasts a single cycle.
    a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: busy is low in the done cycle.
    a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: the driven word does not change between compares.
    a_r2_drive_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmp_now) |=> $stable(drive_o));

    // R4: a start during a run neither ends the run nor moves the step.
    a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !cmp_now) |=> (busy && $stable(step)));

    // R5: pass is never reported together with a non-zero mask.
    a_r5_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (fail_mask == '0));

    // R9: results hold while idle without a start.
    a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(pass) && $stable(fail_mask)));
endmodule

// File: tb/lbt_loopback_tester_tb.sv
module lbt_loopback_tester_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] settle_cycles = 8'd4;
    logic [7:0] drive_o;
    logic [7:0] return_i;
    logic       busy, done, pass;
    logic [7:0] fail_mask, stuck1_mask, stuck0_mask;

    logic [7:0] f_s1 = '0;
    logic [7:0] f_s0 = '0;
    logic       f_bridge = 1'b0;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    lbt_loopback_tester u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
        .drive_o(drive_o), .return_i(return_i), .busy(busy), .done(done),
        .pass(pass), .fail_mask(fail_mask), .stuck1_mask(stuck1_mask),
        .stuck0_mask(stuck0_mask)
    );

    function automatic logic [7:0] path(input logic [7:0] d);
        logic [7:0] r;
        r = d;
        if (f_bridge) begin
            r[3] = d[3] & d[4];
            r[4] = d[3] & d[4];
        end
        return (r | f_s1) & ~f_s0;
    endfunction

    always_comb return_i = path(drive_o);

    function automatic logic [7:0] vec(input int s);
        case (s)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'h00;
            3: return 8'hAA;
            4: return 8'h55;
            5: return 8'hAA;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One run: pulse start, check the word order and timing, then the results.
    task automatic run(input string req, input int settle, input int glitch_at);
        int w, n, m1, s1, s0;
        logic [7:0] e_mask, zok, ook, g;
        w = ((settle == 0) ? 1 : settle) + 2;
        e_mask = '0; zok = '0; ook = '0;
        for (int s = 0; s < 7; s++) begin
            g = path(vec(s));
            e_mask |= g ^ vec(s);
            zok |= ~vec(s) & ~g;
            ook |= vec(s) & g;
        end
        settle_cycles = 8'(settle);
        start = 1'b1;
        @(negedge clk);
        n = 1;
        start = 1'b0;
        settle_cycles = 8'd9;
        check("R3", "busy after start", busy, 1);
        check("R9", "mask cleared at start", fail_mask, 0);
        while (!done && n < 3000) begin
            if ((n - 1) % w == 0 && (n - 1) / w < 7)
                check("R2", "word order", drive_o, vec((n - 1) / w));
            if (n == glitch_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        check(req, "run length", n, 7 * w + 1);
        check("R3", "busy low at done", busy, 0);
        check("R5", "fail mask", fail_mask, e_mask);
        check("R5", "pass", pass, e_mask == 0);
        check("R6", "stuck-high mask", stuck1_mask, e_mask & ~zok);
        check("R7", "stuck-low mask", stuck0_mask, e_mask & ~ook);
        @(negedge clk);
        check("R3", "done one cycle", done, 0);
    endtask

    task automatic t_reset();
        check("R1", "busy", busy, 0);
        check("R1", "done", done, 0);
        check("R1", "pass", pass, 0);
        check("R1", "fail mask", fail_mask, 0);
        check("R1", "stuck masks", {stuck1_mask, stuck0_mask}, 0);
        check("R1", "drive", drive_o, 0);
    endtask

    task automatic t_clean();
        f_s1 = '0; f_s0 = '0; f_bridge = 1'b0;
        run("R2", 4, -1);
        check("R5", "clean pass", pass, 1);
    endtask

    task automatic t_stuck_high();
        f_s1 = 8'h01; f_s0 = '0; f_bridge = 1'b0;
        run("R6", 4, -1);
        check("R6", "bit0 stuck high", stuck1_mask, 8'h01);
        f_s1 = '0;
    endtask

    task automatic t_stuck_low();
        f_s1 = '0; f_s0 = 8'h80; f_bridge = 1'b0;
        run("R7", 3, -1);
        check("R7", "bit7 stuck low", stuck0_mask, 8'h80);
        f_s0 = '0;
    endtask

    task automatic t_bridge();
        f_bridge = 1'b1;
        run("R8", 4, -1);
        check("R8", "bridge mask", fail_mask, 8'h18);
        check("R8", "bridge no stuck", {stuck1_mask, stuck0_mask}, 0);
        f_bridge = 1'b0;
    endtask

    task automatic t_start_busy();
        run("R4", 4, 10);
        check("R4", "pass after ignored start", pass, 1);
    endtask

    task automatic t_settle_zero();
        run("R10", 0, -1);
    endtask

    task automatic t_hold();
        f_s1 = 8'h20;
        run("R9", 2, -1);
        repeat (10) @(negedge clk);
        check("R9", "mask held", fail_mask, 8'h20);
        check("R9", "pass held", pass, 0);
        f_s1 = '0;
        run("R9", 2, -1);
        check("R9", "new run clean", fail_mask, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_stuck_high();
        t_stuck_low();
        t_bridge();
        t_start_busy();
        t_settle_zero();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule